// File: doc/BRIEF.md
# Serial PCM Time-Slot Port for One Voice Channel

This block moves one 8-bit voice sample per frame between a parallel byte interface and a serial PCM highway. A byte handed in on the transmit side is shifted out on the serial output, sign bit first. A byte arriving on the serial input is assembled and handed out on the receive side. Transmit and receive are timed by their own frame-sync inputs against a shared bit clock. The serial output is a tristate pad, brought out as a data bit plus an output enable, and it drives only during the channel's time slot.

The bit clock and frame syncs are oversampled by the block clock, which must run at least four times faster than the bit clock. These inputs are treated as synchronous to that clock. A static mode input picks one of two framing styles:
- **Short framing:** the frame pulse lasts exactly one bit period and is sampled on a falling bit-clock edge.
- **Long framing:** the pulse lasts three bit periods or more, and the transfer is keyed to the pulse's rising edge.

A power-down input silences the channel. Frame pulses that arrive during a transfer are discarded.

The transmit byte path is valid/ready with a single holding register:
- `tx_ready` is high while the holding register is empty.
- A byte is taken on a clock where `tx_valid` and `tx_ready` are both high.
- The holding register is emptied when a transmit frame starts.
- If no byte is waiting when a frame starts, the fill byte is sent instead.

The receive path cannot stall the serial line, so it has no ready. `rx_valid` is a one-cycle pulse that the consumer must take when it appears.

Top module: `pcm_slot_port`

## Requirements
- R1: Serial bytes in both directions are most significant bit first: transmit bit k of the frame (k = 0..7) is `tx_byte[7-k]`, and the k-th captured serial bit lands in `rx_data[7-k]`.
- R2: Short framing (`sync_long`=0), transmit side. When `fsx` is high at a falling `bclk` edge, `dx_oe` rises at the next rising `bclk` edge with the MSB on `dx_bit`. The next 7 rising edges each present the following bit.
- R3: In both framings, the 9th rising `bclk` edge of a transfer, counting the one that began it, drops `dx_oe`. `dx_oe` is 0 out of reset.
- R4: Short framing, receive side. When `fsr` is high at a falling `bclk` edge, the next 8 falling edges sample `dr`.
- R5: Long framing (`sync_long`=1), transmit side. `dx_oe` rises with the MSB at the later of the `fsx` rising edge and a `bclk` rising edge. If `fsx` rises while `bclk` is high, output starts at once. If `fsx` rises while `bclk` is low, output waits for the next rising edge.
- R6: Long framing, receive side. A rising edge on `fsr` starts capture of `dr` on the next 8 falling `bclk` edges.
- R7: After the 8th captured bit, `rx_data` is updated and `rx_valid` pulses for exactly one clock. A transfer that is cut short gives no pulse, and `rx_valid` is 0 out of reset.
- R8: While `pd` is 1, `dx_oe` is 0 and any transfer in progress is abandoned. Frame pulses are ignored, so no output drive and no `rx_valid` result from them.
- R9: A frame pulse that arrives during a transfer, before its last bit, is discarded. The transfer runs to its normal end and no extra frame follows.
- R10: The transmit holding register behaves as follows:
  - `tx_ready` is 1 when it is empty, including out of reset, and 0 when it is full.
  - A full register ignores `tx_valid`.
  - It is emptied at frame start.
  - A frame that starts with it empty sends the fill byte 0xFF.
- R11: In short framing, a frame pulse sampled on the falling edge of a transfer's last bit starts the next transfer without a gap. The 9th rising edge then carries the new MSB with `dx_oe` held high, and reception restarts on the same edge that completes the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| sync_long | input | 1 | Framing style: 0 short, 1 long (static) |
| pd | input | 1 | Channel power-down |
| dr | input | 1 | Serial receive data |
| dx_bit | output | 1 | Serial transmit data value |
| dx_oe | output | 1 | Serial transmit drive enable (0 = high impedance) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register can take a byte |
| rx_data | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` newly updated |

## Verification
The two functions that meet in one cycle are the completion of a received byte and the start of the next short frame. Both happen on the same falling bit-clock edge that samples the last bit and the new frame pulse. On the transmit side, the ending 9th rising edge is also the new frame's first edge.

The bench provokes this by raising both frame syncs during the last bit of a transfer. It then judges two things:
- the first byte still arrives intact with a single `rx_valid` pulse;
- the output stays enabled across the boundary with the new frame's MSB, which is the fill byte because nothing was queued.

A second coincidence is a transmit handshake landing while a frame start empties the holding register. The back-pressure test covers this by offering a byte while the register is full and checking which byte each later frame carries.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef enum logic {
    SYNC_SHORT = 1'b0,
    SYNC_LONG  = 1'b1
  } sync_mode_e;

  localparam int unsigned EDGE_BCLK = 0;
  localparam int unsigned EDGE_FSX  = 1;
  localparam int unsigned EDGE_FSR  = 2;
  localparam int unsigned EDGE_N    = 3;
endpackage

// File: rtl/pcm_edge_sense.sv
module pcm_edge_sense #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] prev
);
  for (genvar g = 0; g < N; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) prev[g] <= 1'b0;
      else        prev[g] <= sig[g];
    end
  end
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_slot_pkg::*;
#(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    FILL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sync_mode_e   mode,
  input  logic         pd,
  input  logic         bclk_lvl,
  input  logic         bclk_rise,
  input  logic         bclk_fall,
  input  logic         fs_lvl,
  input  logic         fs_rise,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         dx_bit,
  output logic         dx_oe
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  hold_q, shift_q;
  logic          full_q, active_q, armed_q;
  logic [CW-1:0] cnt_q;
  logic          last_bit, may_arm, trig, start, set_arm, accept;

  assign last_bit = active_q && (cnt_q == CW'(W));
  assign may_arm  = !active_q || last_bit;
  assign trig     = (mode == SYNC_LONG) ? ((armed_q || fs_rise) && bclk_lvl)
                                        : (armed_q && bclk_rise);
  assign start    = !pd && (!active_q || (last_bit && bclk_rise)) && trig;
  assign set_arm  = !pd && may_arm &&
                    ((mode == SYNC_LONG) ? fs_rise : (bclk_fall && fs_lvl));
  assign in_ready = !full_q;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      full_q   <= 1'b0;
      shift_q  <= '0;
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (accept) begin
        hold_q <= in_data;
        full_q <= 1'b1;
      end else if (start) begin
        full_q <= 1'b0;
      end

      if (pd) begin
        active_q <= 1'b0;
        armed_q  <= 1'b0;
        cnt_q    <= '0;
      end else if (start) begin
        active_q <= 1'b1;
        armed_q  <= 1'b0;
        cnt_q    <= CW'(1);
        shift_q  <= full_q ? hold_q : FILL;
      end else begin
        if (set_arm) armed_q <= 1'b1;
        if (active_q && bclk_rise) begin
          if (last_bit) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
          end else begin
            cnt_q   <= cnt_q + CW'(1);
            shift_q <= {shift_q[W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign dx_oe  = active_q;
  assign dx_bit = shift_q[W-1];

  a_r8_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !dx_oe);
  a_r2_short_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SYNC_SHORT && $rose(active_q)) |-> $past(bclk_rise));
  a_r5_long_start_bclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SYNC_LONG && $rose(active_q)) |-> $past(bclk_lvl));
  a_r1_shift_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$stable(shift_q)) |-> $past(bclk_rise));
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !start) |=> (full_q && $stable(hold_q)));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_slot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sync_mode_e   mode,
  input  logic         pd,
  input  logic         bclk_fall,
  input  logic         fs_lvl,
  input  logic         fs_rise,
  input  logic         dr,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  shift_q;
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          done, start;

  assign done  = active_q && bclk_fall && (cnt_q == CW'(W - 1));
  assign start = !pd && (!active_q || done) &&
                 ((mode == SYNC_LONG) ? fs_rise : (bclk_fall && fs_lvl));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q   <= '0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (pd) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (active_q && bclk_fall) begin
        shift_q <= {shift_q[W-2:0], dr};
        if (done) begin
          out_data  <= {shift_q[W-2:0], dr};
          out_valid <= 1'b1;
          active_q  <= 1'b0;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r7_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(bclk_fall));
  a_r8_pd_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !out_valid);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] FILL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsx,
  input  logic         fsr,
  input  logic         sync_long,
  input  logic         pd,
  input  logic         dr,
  output logic         dx_bit,
  output logic         dx_oe,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  logic [EDGE_N-1:0] lvl, prev;
  logic bclk_rise, bclk_fall, fsx_rise, fsr_rise;
  sync_mode_e mode;

  assign lvl[EDGE_BCLK] = bclk;
  assign lvl[EDGE_FSX]  = fsx;
  assign lvl[EDGE_FSR]  = fsr;
  assign mode = sync_long ? SYNC_LONG : SYNC_SHORT;

  pcm_edge_sense #(.N(EDGE_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig(lvl), .prev(prev)
  );

  assign bclk_rise = bclk  && !prev[EDGE_BCLK];
  assign bclk_fall = !bclk &&  prev[EDGE_BCLK];
  assign fsx_rise  = fsx   && !prev[EDGE_FSX];
  assign fsr_rise  = fsr   && !prev[EDGE_FSR];

  pcm_tx_slot #(.W(W), .FILL(FILL)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pd(pd),
    .bclk_lvl(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .fs_lvl(fsx), .fs_rise(fsx_rise),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
    .dx_bit(dx_bit), .dx_oe(dx_oe)
  );

  pcm_rx_slot #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pd(pd),
    .bclk_fall(bclk_fall), .fs_lvl(fsr), .fs_rise(fsr_rise), .dr(dr),
    .out_data(rx_data), .out_valid(rx_valid)
  );

  a_r3_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!dx_oe && !rx_valid && tx_ready));
endmodule

// File: tb/sim_pcm_slot_port.sv
`timescale 1ns/1ps
module sim_pcm_slot_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsx = 1'b0, fsr = 1'b0, sync_long = 1'b0, pd = 1'b0, dr = 1'b0;
  logic dx_bit, dx_oe, tx_ready, rx_valid, tx_valid = 1'b0;
  logic [7:0] tx_data = '0, rx_data;

  int n_chk = 0, n_fail = 0, rx_cnt = 0;
  logic [7:0] rx_last = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pcm_slot_port u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsx(fsx), .fsr(fsr),
    .sync_long(sync_long), .pd(pd), .dr(dr), .dx_bit(dx_bit), .dx_oe(dx_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin
    rx_cnt  <= rx_cnt + 1;
    rx_last <= rx_data;
  end

  // {mode[1:0], tx byte, rx byte}; mode 0 short, 1 long fs-in-low, 2 long fs-in-high
  localparam logic [17:0] VEC [7] = '{
    {2'd0, 8'hA5, 8'h3C}, {2'd0, 8'h01, 8'h80}, {2'd1, 8'hF0, 8'h0F},
    {2'd1, 8'h5A, 8'hC3}, {2'd2, 8'h80, 8'h01}, {2'd2, 8'h7E, 8'hE7},
    {2'd0, 8'h00, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic half();
    wclk(4);
  endtask

  task automatic push(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // mode 3: short frame already armed by a chained pulse
  task automatic run_frame(input logic [1:0] mode, input logic [7:0] txb, input logic [7:0] rxb,
                           input bit resync, input bit chain);
    int c0;
    bit shrt;
    string ttag, rtag;
    c0   = rx_cnt;
    shrt = (mode == 2'd0) || (mode == 2'd3);
    ttag = shrt ? "R2" : "R5";
    rtag = shrt ? "R4" : "R6";
    sync_long = !shrt;
    if (mode == 2'd0) begin
      bclk = 1'b1; fsx = 1'b1; fsr = 1'b1; half();
      bclk = 1'b0; half();
    end else if (mode == 2'd1) begin
      wclk(2); fsx = 1'b1; fsr = 1'b1; wclk(2);
      chk(!dx_oe, "R5 wait for rising bclk", dx_oe, 0);
    end
    for (int i = 0; i < 8; i++) begin
      bclk = 1'b1; dr = rxb[7-i];
      if (shrt && i == 0) begin fsx = 1'b0; fsr = 1'b0; end
      if (!shrt && i == 3) begin fsx = 1'b0; fsr = 1'b0; end
      if (resync && i == 4) begin fsx = 1'b1; fsr = 1'b1; end
      if (resync && i == 5) begin fsx = 1'b0; fsr = 1'b0; end
      if (chain && i == 7) begin fsx = 1'b1; fsr = 1'b1; end
      if (mode == 2'd2 && i == 0) begin
        wclk(2);
        chk(!dx_oe, "R5 idle before fsx", dx_oe, 0);
        fsx = 1'b1; fsr = 1'b1;
        wclk(2);
        chk(dx_oe && dx_bit == txb[7], "R5 immediate start", {dx_oe, dx_bit}, {1'b1, txb[7]});
      end else begin
        wclk(2);
        chk(dx_oe && dx_bit == txb[7-i], (i == 0) ? ttag : (resync ? "R9" : "R1"),
            {dx_oe, dx_bit}, {1'b1, txb[7-i]});
        wclk(2);
      end
      bclk = 1'b0; half();
    end
    chk(rx_cnt == c0 + 1 && rx_last == rxb, chain ? "R11 rx" : rtag,
        {rx_cnt - c0, 8'(rx_last)}, {32'd1, rxb});
    chk(rx_last == rxb, "R7", rx_last, rxb);
    if (!chain) begin
      bclk = 1'b1; wclk(2);
      chk(!dx_oe, resync ? "R9 no extra frame" : "R3", dx_oe, 0);
      wclk(2); bclk = 1'b0; half();
    end
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(1);
    chk(!dx_oe, "R3 reset", dx_oe, 0);
    chk(!rx_valid, "R7 reset", rx_valid, 0);
    chk(tx_ready, "R10 reset", tx_ready, 1);

    for (int k = 0; k < 7; k++) begin
      push(VEC[k][15:8]);
      run_frame(VEC[k][17:16], VEC[k][15:8], VEC[k][7:0], 1'b0, 1'b0);
      half();
    end

    // R10: back-pressure and underrun fill
    push(8'h3C);
    chk(!tx_ready, "R10 full", tx_ready, 0);
    tx_data = 8'hC3; tx_valid = 1'b1; wclk(6); tx_valid = 1'b0;
    chk(!tx_ready, "R10 still full", tx_ready, 0);
    run_frame(2'd0, 8'h3C, 8'h11, 1'b0, 1'b0);
    chk(tx_ready, "R10 emptied", tx_ready, 1);
    run_frame(2'd1, 8'hFF, 8'h22, 1'b0, 1'b0);

    // R9: resync pulse mid-frame
    push(8'hA5);
    run_frame(2'd0, 8'hA5, 8'h5A, 1'b1, 1'b0);

    // R11: chained short frames, second sends fill
    push(8'h96);
    run_frame(2'd0, 8'h96, 8'h69, 1'b0, 1'b1);
    run_frame(2'd3, 8'hFF, 8'hC7, 1'b0, 1'b0);

    // R8: power-down aborts and blocks frames
    push(8'h81);
    sync_long = 1'b0;
    bclk = 1'b1; fsx = 1'b1; fsr = 1'b1; half();
    bclk = 1'b0; half();
    for (int i = 0; i < 3; i++) begin
      bclk = 1'b1; fsx = 1'b0; fsr = 1'b0; dr = 1'b1; half();
      bclk = 1'b0; half();
    end
    begin
      int c0;
      c0 = rx_cnt;
      pd = 1'b1; wclk(2);
      chk(!dx_oe, "R8 abort", dx_oe, 0);
      for (int i = 3; i < 9; i++) begin
        bclk = 1'b1; wclk(2);
        chk(!dx_oe, "R8 quiet", dx_oe, 0);
        wclk(2); bclk = 1'b0; half();
      end
      chk(rx_cnt == c0, "R7 partial dropped", rx_cnt - c0, 0);
      bclk = 1'b1; fsx = 1'b1; fsr = 1'b1; half();
      bclk = 1'b0; half(); fsx = 1'b0; fsr = 1'b0;
      for (int i = 0; i < 9; i++) begin
        bclk = 1'b1; wclk(2);
        chk(!dx_oe, "R8 frame ignored", dx_oe, 0);
        wclk(2); bclk = 1'b0; half();
      end
      chk(rx_cnt == c0, "R8 no rx", rx_cnt - c0, 0);
    end
    pd = 1'b0; half();
    push(8'h42);
    run_frame(2'd2, 8'h42, 8'h24, 1'b0, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule